// File: doc/BRIEF.md
# MESI Line Coherence Controller

This block holds the four-state coherence tag of every line in a small private write-back cache that sits on a snooping shared bus. Data arrays, tags and victim selection live elsewhere. The block keeps only the per-line state. It sequences the one bus transaction that a processor request may need, and it answers snoops from the other caches on the bus.

The processor side offers a request with a valid/ready handshake. The request carries an operation and a line index. The operations are read, write, clean (write dirty data back and keep the line) and drop (give up the line). A request that needs no bus traffic completes in the cycle it is presented, with `cpu_hit` high. Any other request raises `bus_req` with a command. It waits for `bus_gnt`, holds the bus until `bus_done`, and then completes. Only one bus transaction is outstanding at a time. The snoop side receives a read or an invalidate from another cache. It answers in the same cycle with `snp_shared` when the line is held, and with `snp_flush` when it must supply dirty data. The line state changes at the next clock edge.

The request sequencer has three states. `RQ_IDLE` completes hits locally, or moves to `RQ_ARB` when bus work is needed. `RQ_ARB` asserts the request and moves to `RQ_XFER` on grant. It can also return to `RQ_IDLE` if a snoop has already removed the need for bus work. `RQ_XFER` holds the bus and returns to `RQ_IDLE` on `bus_done`. The bus arbiter never grants this cache in a cycle that carries a snoop, and no snoop arrives while this cache owns the bus.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. A snoop read of any index then sees `snp_shared` and `snp_flush` both low.
- R2: A read (`cpu_op`=0) of a Modified, Exclusive or Shared line completes in the cycle it is presented, with `cpu_ready` and `cpu_hit` high and `bus_req` low. A read of an Invalid line issues bus command 0 (fetch).
- R3: When a fetch finishes, the line becomes Exclusive if `bus_shared_in` is low in the `bus_done` cycle, and Shared otherwise.
- R4: A write (`cpu_op`=1) to a Modified or Exclusive line completes locally and leaves the line Modified. A write to an Invalid line issues bus command 1 (fetch for ownership) and leaves the line Modified.
- R5: A write to a Shared line issues bus command 2 (invalidate broadcast). It completes only at `bus_done`, leaving the line Modified.
- R6: A snoop read (`snp_cmd`=0) moves a Modified or Exclusive line to Shared. A Shared or Invalid line is unchanged.
- R7: A snoop invalidate (`snp_cmd`=1, also used for another cache's fetch for ownership) moves the line to Invalid.
- R8: While `snp_valid` is high, `snp_shared` is high exactly when the snooped line is not Invalid, and `snp_flush` is high exactly when it is Modified.
- R9: A clean (`cpu_op`=2) of a Modified line issues bus command 3 (write-back) and leaves the line Exclusive. A clean of any other line completes locally with no change.
- R10: A drop (`cpu_op`=3) of a Shared, Exclusive or Invalid line completes locally and leaves it Invalid. A drop of a Modified line issues bus command 3 first and then leaves it Invalid.
- R11: A Shared line never becomes Exclusive in the next cycle.
- R12: A snoop to the requested index holds `cpu_ready` low in that cycle. Until grant, the bus command is re-derived from the current line state. A Shared line invalidated while waiting turns command 2 into command 1. A request whose bus work is removed by a snoop completes with `cpu_ready` high and `cpu_hit` low.
- R13: `bus_req` stays high from grant through `bus_done`, and `bus_cmd` does not change during the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor request present, held until ready |
| cpu_op | input | 2 | 0 read, 1 write, 2 clean, 3 drop |
| cpu_idx | input | IDX_W | Line index of the request |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_hit | output | 1 | Completion needed no bus work |
| bus_req | output | 1 | Bus transaction requested or in progress |
| bus_cmd | output | 2 | 0 fetch, 1 fetch for ownership, 2 invalidate, 3 write-back |
| bus_gnt | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Bus transaction finished |
| bus_shared_in | input | 1 | Another cache holds the fetched line (valid with bus_done) |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 1 | 0 read, 1 invalidate |
| snp_idx | input | IDX_W | Snooped line index |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_flush | output | 1 | This cache supplies dirty data for the snooped line |

## Verification
The line state is not visible at the ports, so a wrong state shows up only at the next access to that line. A wrong Modified/Exclusive split appears on the next clean, which either issues a write-back or completes as a hit. A wrong Shared/Exclusive split appears on the next write, which either issues an invalidate broadcast or completes as a hit. A lost line appears as a fetch command on the next read, and `snp_flush` or `snp_shared` is wrong in the first snoop cycle after the fault. The bench therefore follows each operation with a clean and then a write to the same line, so every wrong state becomes visible within a few cycles. Snoops that arrive while a request waits for the bus are covered by separate cases, because there a wrong state changes the bus command before the grant.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_EXC = 2'd2,
        LN_MOD = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        OP_RD    = 2'd0,
        OP_WR    = 2'd1,
        OP_CLEAN = 2'd2,
        OP_DROP  = 2'd3
    } cpu_op_e;

    typedef enum logic [1:0] {
        BC_READ  = 2'd0,
        BC_RDOWN = 2'd1,
        BC_UPGR  = 2'd2,
        BC_WBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic {
        SN_READ = 1'b0,
        SN_KILL = 1'b1
    } snp_cmd_e;

    typedef enum logic [1:0] {
        RQ_IDLE = 2'd0,
        RQ_ARB  = 2'd1,
        RQ_XFER = 2'd2
    } rq_st_e;

    typedef struct packed {
        logic     need;
        bus_cmd_e cmd;
        line_st_e local_nxt;
    } access_plan_t;

    // Decide whether a processor operation needs the bus, and which state it leaves locally.
    function automatic access_plan_t plan_access(line_st_e st, cpu_op_e op);
        access_plan_t p;
        p.need      = 1'b0;
        p.cmd       = BC_READ;
        p.local_nxt = st;
        case (op)
            OP_RD: begin
                if (st == LN_INV) begin
                    p.need = 1'b1;
                    p.cmd  = BC_READ;
                end
            end
            OP_WR: begin
                if (st == LN_INV) begin
                    p.need = 1'b1;
                    p.cmd  = BC_RDOWN;
                end else if (st == LN_SHR) begin
                    p.need = 1'b1;
                    p.cmd  = BC_UPGR;
                end else begin
                    p.local_nxt = LN_MOD;
                end
            end
            OP_CLEAN: begin
                if (st == LN_MOD) begin
                    p.need = 1'b1;
                    p.cmd  = BC_WBACK;
                end
            end
            OP_DROP: begin
                if (st == LN_MOD) begin
                    p.need = 1'b1;
                    p.cmd  = BC_WBACK;
                end else begin
                    p.local_nxt = LN_INV;
                end
            end
            default: ;
        endcase
        return p;
    endfunction

    // State left behind once a bus transaction of this cache finishes.
    function automatic line_st_e fill_result(bus_cmd_e c, cpu_op_e op, logic others);
        line_st_e r;
        case (c)
            BC_READ:  r = others ? LN_SHR : LN_EXC;
            BC_RDOWN: r = LN_MOD;
            BC_UPGR:  r = LN_MOD;
            BC_WBACK: r = (op == OP_DROP) ? LN_INV : LN_EXC;
            default:  r = LN_INV;
        endcase
        return r;
    endfunction

    // State left behind after observing another cache's transaction.
    function automatic line_st_e snoop_result(line_st_e st, snp_cmd_e k);
        line_st_e r;
        if (k == SN_KILL) begin
            r = LN_INV;
        end else if (st == LN_MOD || st == LN_EXC) begin
            r = LN_SHR;
        end else begin
            r = st;
        end
        return r;
    endfunction

endpackage

// File: rtl/mesi_state_array.sv
module mesi_state_array
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_en,
    input  logic [IDX_W-1:0] snp_at,
    input  line_st_e         snp_val,
    input  logic             own_en,
    input  logic [IDX_W-1:0] own_at,
    input  line_st_e         own_val,
    output line_st_e         line_q [NUM_LINES]
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        // Own-side updates win; the handshake rules keep both ports off one line in one cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q[g] <= LN_INV;
            end else if (own_en && own_at == IDX_W'(g)) begin
                line_q[g] <= own_val;
            end else if (snp_en && snp_at == IDX_W'(g)) begin
                line_q[g] <= snp_val;
            end
        end

        p_no_promote_r11: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(line_q[g]) == LN_SHR) |-> (line_q[g] != LN_EXC))
            else $error("shared line promoted to exclusive");
    end

endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
(
    input  logic     snp_valid,
    input  snp_cmd_e snp_kind,
    input  line_st_e cur_st,
    output logic     held,
    output logic     flush,
    output logic     upd_en,
    output line_st_e upd_val
);

    always_comb begin
        held    = snp_valid && (cur_st != LN_INV);
        flush   = snp_valid && (cur_st == LN_MOD);
        upd_en  = snp_valid;
        upd_val = snoop_result(cur_st, snp_kind);
    end

endmodule

// File: rtl/mesi_req_fsm.sv
module mesi_req_fsm
    import mesi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cpu_valid,
    input  cpu_op_e  op,
    input  line_st_e cur_st,
    input  logic     conflict,
    input  logic     bus_gnt,
    input  logic     bus_done,
    input  logic     bus_shared_in,
    output logic     cpu_ready,
    output logic     cpu_hit,
    output logic     bus_req,
    output bus_cmd_e bus_cmd,
    output logic     upd_en,
    output line_st_e upd_val
);

    rq_st_e       state_q, state_d;
    bus_cmd_e     cmd_q;
    access_plan_t acc;

    // State register and the command latched at grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RQ_IDLE;
            cmd_q   <= BC_READ;
        end else begin
            state_q <= state_d;
            if (state_q == RQ_ARB && state_d == RQ_XFER) begin
                cmd_q <= acc.cmd;
            end
        end
    end

    // Next state and outputs.
    always_comb begin
        acc       = plan_access(cur_st, op);
        state_d   = state_q;
        cpu_ready = 1'b0;
        cpu_hit   = 1'b0;
        bus_req   = 1'b0;
        bus_cmd   = acc.cmd;
        upd_en    = 1'b0;
        upd_val   = acc.local_nxt;
        unique case (state_q)
            RQ_IDLE: begin
                if (cpu_valid && !conflict) begin
                    if (!acc.need) begin
                        cpu_ready = 1'b1;
                        cpu_hit   = 1'b1;
                        upd_en    = 1'b1;
                    end else begin
                        state_d = RQ_ARB;
                    end
                end
            end
            RQ_ARB: begin
                if (acc.need) begin
                    bus_req = 1'b1;
                    if (bus_gnt) begin
                        state_d = RQ_XFER;
                    end
                end else if (!conflict) begin
                    cpu_ready = 1'b1;
                    upd_en    = 1'b1;
                    state_d   = RQ_IDLE;
                end
            end
            RQ_XFER: begin
                bus_req = 1'b1;
                bus_cmd = cmd_q;
                if (bus_done) begin
                    cpu_ready = 1'b1;
                    upd_en    = 1'b1;
                    upd_val   = fill_result(cmd_q, op, bus_shared_in);
                    state_d   = RQ_IDLE;
                end
            end
            default: state_d = RQ_IDLE;
        endcase
    end

    p_req_held_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RQ_XFER && !bus_done) |=> bus_req)
        else $error("bus request dropped during transfer");

    p_cmd_stable_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RQ_XFER && $past(state_q) == RQ_XFER) |-> $stable(bus_cmd))
        else $error("bus command changed during transfer");

    p_hit_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_hit |-> (cpu_ready && !bus_req))
        else $error("hit reported with bus activity");

    p_ready_has_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid)
        else $error("ready without a request");

endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 4,
    localparam int IDX_W = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic [1:0]       cpu_op,
    input  logic [IDX_W-1:0] cpu_idx,
    output logic             cpu_ready,
    output logic             cpu_hit,
    output logic             bus_req,
    output logic [1:0]       bus_cmd,
    input  logic             bus_gnt,
    input  logic             bus_done,
    input  logic             bus_shared_in,
    input  logic             snp_valid,
    input  logic             snp_cmd,
    input  logic [IDX_W-1:0] snp_idx,
    output logic             snp_shared,
    output logic             snp_flush
);

    line_st_e line_q [NUM_LINES];
    line_st_e own_st, snp_st;
    line_st_e own_val, snp_val;
    logic     own_en, snp_en, conflict;
    bus_cmd_e cmd_w;

    assign own_st   = line_q[cpu_idx];
    assign snp_st   = line_q[snp_idx];
    assign conflict = snp_valid && (snp_idx == cpu_idx);
    assign bus_cmd  = cmd_w;

    mesi_state_array #(.NUM_LINES(NUM_LINES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .snp_en  (snp_en),
        .snp_at  (snp_idx),
        .snp_val (snp_val),
        .own_en  (own_en),
        .own_at  (cpu_idx),
        .own_val (own_val),
        .line_q  (line_q)
    );

    mesi_snoop_unit u_snoop (
        .snp_valid (snp_valid),
        .snp_kind  (snp_cmd_e'(snp_cmd)),
        .cur_st    (snp_st),
        .held      (snp_shared),
        .flush     (snp_flush),
        .upd_en    (snp_en),
        .upd_val   (snp_val)
    );

    mesi_req_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_valid     (cpu_valid),
        .op            (cpu_op_e'(cpu_op)),
        .cur_st        (own_st),
        .conflict      (conflict),
        .bus_gnt       (bus_gnt),
        .bus_done      (bus_done),
        .bus_shared_in (bus_shared_in),
        .cpu_ready     (cpu_ready),
        .cpu_hit       (cpu_hit),
        .bus_req       (bus_req),
        .bus_cmd       (cmd_w),
        .upd_en        (own_en),
        .upd_val       (own_val)
    );

    p_write_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && cpu_op == 2'd1) |=> (line_q[$past(cpu_idx)] == LN_MOD))
        else $error("completed write did not leave line modified");

    p_read_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ready && cpu_op == 2'd0) |=> (line_q[$past(cpu_idx)] != LN_INV))
        else $error("completed read left line invalid");

    p_clean_exc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && bus_done && bus_req && cpu_op == 2'd2) |=> (line_q[$past(cpu_idx)] == LN_EXC))
        else $error("write-back by clean did not leave line exclusive");

    p_flush_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        snp_flush |-> snp_shared)
        else $error("flush without holding the line");

    p_kill_inv_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && snp_cmd && !(cpu_ready && cpu_idx == snp_idx)) |=> (line_q[$past(snp_idx)] == LN_INV))
        else $error("snooped invalidate left line valid");

endmodule

// File: tb/mesi_line_ctrl_tb_top.sv
module mesi_line_ctrl_tb_top;

    localparam int CLK_P = 10;
    localparam int QTR   = CLK_P / 4;
    localparam int NL    = 4;
    localparam int IW    = 2;
    localparam int S_I = 0, S_S = 1, S_E = 2, S_M = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_valid = 1'b0;
    logic [1:0]    cpu_op = 2'd0;
    logic [IW-1:0] cpu_idx = '0;
    logic          cpu_ready, cpu_hit, bus_req;
    logic [1:0]    bus_cmd;
    logic          bus_gnt = 1'b0, bus_done = 1'b0, bus_shared_in = 1'b0;
    logic          snp_valid = 1'b0, snp_cmd = 1'b0;
    logic [IW-1:0] snp_idx = '0;
    logic          snp_shared, snp_flush;

    int  n_tot = 0;
    int  n_bad = 0;
    bit  finished = 0;
    int  mdl [NL];

    always #(CLK_P/2) clk = ~clk;

    mesi_line_ctrl #(.NUM_LINES(NL)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_valid(cpu_valid), .cpu_op(cpu_op), .cpu_idx(cpu_idx),
        .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_gnt(bus_gnt),
        .bus_done(bus_done), .bus_shared_in(bus_shared_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_idx(snp_idx),
        .snp_shared(snp_shared), .snp_flush(snp_flush)
    );

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_tot++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic string op_req(input int op, input int st);
        case (op)
            0: return "R2";
            1: return (st == S_S) ? "R5" : "R4";
            2: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic void plan(input int st, input int op, output bit need, output int cmd);
        need = 0; cmd = 0;
        case (op)
            0: if (st == S_I) begin need = 1; cmd = 0; end
            1: begin
                if (st == S_I) begin need = 1; cmd = 1; end
                else if (st == S_S) begin need = 1; cmd = 2; end
            end
            2: if (st == S_M) begin need = 1; cmd = 3; end
            default: if (st == S_M) begin need = 1; cmd = 3; end
        endcase
    endfunction

    function automatic int after_local(input int st, input int op);
        if (op == 1) return S_M;
        if (op == 3) return S_I;
        return st;
    endfunction

    function automatic int after_bus(input int cmd, input int op, input bit shin);
        case (cmd)
            0: return shin ? S_S : S_E;
            1, 2: return S_M;
            default: return (op == 3) ? S_I : S_E;
        endcase
    endfunction

    // Entered and left at a negative edge.
    task automatic do_cpu(input int op, input int idx, input bit shin, input int gdly, input int ddly);
        bit    need;
        int    cmd;
        string rq;
        plan(mdl[idx], op, need, cmd);
        rq = op_req(op, mdl[idx]);
        cpu_valid = 1'b1; cpu_op = op[1:0]; cpu_idx = idx[IW-1:0];
        #QTR;
        if (!need) begin
            chk(cpu_ready == 1'b1, rq, "local ready", cpu_ready, 1);
            chk(cpu_hit == 1'b1, rq, "local hit", cpu_hit, 1);
            chk(bus_req == 1'b0, rq, "local no bus_req", bus_req, 0);
            @(posedge clk);
            mdl[idx] = after_local(mdl[idx], op);
        end else begin
            chk(cpu_ready == 1'b0, rq, "miss stalls", cpu_ready, 0);
            @(posedge clk); @(negedge clk);
            for (int k = 0; k < gdly; k++) begin
                #QTR;
                chk(bus_req == 1'b1, "R13", "req while waiting", bus_req, 1);
                chk(bus_cmd == cmd[1:0], rq, "cmd while waiting", bus_cmd, cmd);
                @(posedge clk); @(negedge clk);
            end
            bus_gnt = 1'b1;
            #QTR;
            chk(bus_req == 1'b1, "R13", "req at grant", bus_req, 1);
            chk(bus_cmd == cmd[1:0], rq, "cmd at grant", bus_cmd, cmd);
            @(posedge clk); @(negedge clk);
            bus_gnt = 1'b0;
            for (int k = 0; k < ddly; k++) begin
                #QTR;
                chk(bus_req == 1'b1 && cpu_ready == 1'b0, "R13", "hold before done", bus_req, 1);
                chk(bus_cmd == cmd[1:0], "R13", "cmd held", bus_cmd, cmd);
                @(posedge clk); @(negedge clk);
            end
            bus_done = 1'b1; bus_shared_in = shin;
            #QTR;
            chk(cpu_ready == 1'b1, rq, "ready at done", cpu_ready, 1);
            chk(cpu_hit == 1'b0, rq, "no hit after bus", cpu_hit, 0);
            chk(bus_cmd == cmd[1:0], "R13", "cmd at done", bus_cmd, cmd);
            @(posedge clk);
            mdl[idx] = after_bus(cmd, op, shin);
        end
        @(negedge clk);
        cpu_valid = 1'b0; bus_done = 1'b0; bus_shared_in = 1'b0;
    endtask

    task automatic do_snoop(input int kind, input int idx);
        string rq;
        rq = (kind == 0) ? "R6" : "R7";
        snp_valid = 1'b1; snp_cmd = kind[0]; snp_idx = idx[IW-1:0];
        #QTR;
        chk(snp_shared == (mdl[idx] != S_I), "R8", "snp_shared", snp_shared, int'(mdl[idx] != S_I));
        chk(snp_flush == (mdl[idx] == S_M), rq, "snp_flush", snp_flush, int'(mdl[idx] == S_M));
        @(posedge clk);
        if (kind == 1) mdl[idx] = S_I;
        else if (mdl[idx] == S_M || mdl[idx] == S_E) mdl[idx] = S_S;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic force_state(input int idx, input int tgt);
        case (tgt)
            S_I: do_cpu(3, idx, 0, 0, 0);
            S_S: begin do_cpu(3, idx, 0, 0, 0); do_cpu(0, idx, 1, 1, 0); end
            S_E: begin do_cpu(3, idx, 0, 0, 0); do_cpu(0, idx, 0, 0, 1); end
            default: do_cpu(1, idx, 0, 1, 1);
        endcase
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tot++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lf;
        for (int i = 0; i < NL; i++) mdl[i] = S_I;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        #QTR;
        chk(cpu_ready == 1'b0 && bus_req == 1'b0, "R1", "idle after reset", bus_req, 0);
        @(negedge clk);
        for (int i = 0; i < NL; i++) do_snoop(0, i);

        // Sweep every line, start state, operation and sharer response; probe with clean then write.
        for (int i = 0; i < NL; i++)
            for (int st = 0; st < 4; st++)
                for (int op = 0; op < 4; op++)
                    for (int sh = 0; sh < 2; sh++) begin
                        force_state(i, st);
                        do_cpu(op, i, sh[0], (st + op) % 3, (op + sh) % 2);
                        do_cpu(2, i, 0, 0, 0);
                        do_cpu(1, i, 0, sh, 0);
                        do_snoop(sh, i);
                    end

        // R12: snoop to the requested line in the same cycle stalls it
        force_state(0, S_E);
        cpu_valid = 1'b1; cpu_op = 2'd1; cpu_idx = 2'd0;
        snp_valid = 1'b1; snp_cmd = 1'b0; snp_idx = 2'd0;
        #QTR;
        chk(cpu_ready == 1'b0, "R12", "stall on same-index snoop", cpu_ready, 0);
        chk(snp_shared == 1'b1 && snp_flush == 1'b0, "R6", "exclusive snooped", snp_shared, 1);
        @(posedge clk); @(negedge clk);
        snp_valid = 1'b0;
        #QTR;
        chk(cpu_ready == 1'b0, "R12", "write now needs bus", cpu_ready, 0);
        @(posedge clk); @(negedge clk);
        #QTR;
        chk(bus_req == 1'b1 && bus_cmd == 2'd2, "R5", "invalidate after downgrade", bus_cmd, 2);
        @(negedge clk);
        bus_gnt = 1'b1; @(posedge clk); @(negedge clk); bus_gnt = 1'b0;
        bus_done = 1'b1; #QTR;
        chk(cpu_ready == 1'b1, "R5", "upgrade completes", cpu_ready, 1);
        @(posedge clk); @(negedge clk);
        bus_done = 1'b0; cpu_valid = 1'b0;
        mdl[0] = S_M;
        do_cpu(2, 0, 0, 0, 0);

        // R12: invalidate while waiting turns the upgrade into a fetch for ownership
        force_state(1, S_S);
        cpu_valid = 1'b1; cpu_op = 2'd1; cpu_idx = 2'd1;
        @(posedge clk); @(negedge clk);
        #QTR;
        chk(bus_cmd == 2'd2, "R12", "upgrade before kill", bus_cmd, 2);
        snp_valid = 1'b1; snp_cmd = 1'b1; snp_idx = 2'd1;
        #QTR;
        chk(snp_shared == 1'b1 && cpu_ready == 1'b0, "R12", "kill while waiting", snp_shared, 1);
        @(posedge clk); @(negedge clk);
        snp_valid = 1'b0;
        #QTR;
        chk(bus_req == 1'b1 && bus_cmd == 2'd1, "R12", "rederived to ownership fetch", bus_cmd, 1);
        @(negedge clk);
        bus_gnt = 1'b1; @(posedge clk); @(negedge clk); bus_gnt = 1'b0;
        bus_done = 1'b1; #QTR;
        chk(cpu_ready == 1'b1 && cpu_hit == 1'b0, "R4", "ownership fetch done", cpu_ready, 1);
        @(posedge clk); @(negedge clk);
        bus_done = 1'b0; cpu_valid = 1'b0;
        mdl[1] = S_M;
        do_snoop(0, 1);

        // R12: clean of a modified line made clean by a snoop completes without bus
        force_state(2, S_M);
        cpu_valid = 1'b1; cpu_op = 2'd2; cpu_idx = 2'd2;
        @(posedge clk); @(negedge clk);
        snp_valid = 1'b1; snp_cmd = 1'b0; snp_idx = 2'd2;
        #QTR;
        chk(bus_cmd == 2'd3 && snp_flush == 1'b1, "R6", "modified flushes on snoop read", snp_flush, 1);
        @(posedge clk); @(negedge clk);
        snp_valid = 1'b0;
        #QTR;
        chk(cpu_ready == 1'b1 && cpu_hit == 1'b0 && bus_req == 1'b0, "R12", "clean dissolved", cpu_ready, 1);
        @(posedge clk); @(negedge clk);
        cpu_valid = 1'b0;
        mdl[2] = S_S;
        do_cpu(1, 2, 0, 0, 0);

        // Pseudo-random mix of requests and snoops
        lf = 16'hACE1;
        for (int n = 0; n < 400; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[1:0] == 2'd3) do_snoop(int'(lf[10]), int'(lf[3:2]));
            else do_cpu(int'(lf[5:4]), int'(lf[3:2]), lf[6], int'(lf[8:7]) % 3, int'(lf[9]));
        end

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", n_tot, n_bad);
            $finish;
        end
    end

endmodule